// File: doc/BRIEF.md
# CPU Clock-Rate Enable Generator

This block sets the pace of a CPU that runs entirely on one master clock. It produces an enable pulse one master cycle wide. The CPU advances only on cycles where the enable is high. Eight rates are available, all taken from a single free-running binary counter, and a 3-bit rate code chooses among them. The chosen tap is registered in the master domain, so the pulse is aligned to the master clock.

Software can write a new rate code at any time. The block stores the code at once but holds it back until the divide counter rolls over. At that point every tap is at its terminal value. The change of rate therefore never produces a pulse that comes early or a gap shorter than the faster of the two rates. The interface is plain control: a code bus with a one-cycle write strobe, and no handshake.

Top module: `cpu_rate_gen`

## Requirements
- R1: While reset is asserted the enable output is low. After reset the active code is 3'b010, which divides by 2, so the enable is high after master edge k (counted from the first edge after reset release) exactly when k is even.
- R2: Codes 3'b000, 3'b001, 3'b010 and 3'b011 give periods of 8, 4, 2 and 1 master cycles. With active divisor N, the enable is high after edge k exactly when k mod N is 0.
- R3: Codes 3'b100, 3'b101, 3'b110 and 3'b111 give periods of 16, 32, 128 and 256 master cycles, with the same phase rule as R2.
- R4: Under code 3'b011 the enable is high on every cycle.
- R5: For any divisor of 2 or more, the enable never stays high for two cycles in a row, except at a rollover where the new divisor is 1.
- R6: A code written while the strobe is high is stored, but the old rate stays in force until the edge where k mod 256 is 0. The new rate governs edges from k+1 onward.
- R7: If several codes are written within one counter period, only the last one written before the rollover takes effect.
- R8: A code written on the same edge as the rollover takes effect at that rollover.
- R9: The enable is high after every edge where k mod 256 is 0, whichever code is active. As a result, no interval between pulses is shorter than the smaller of the old and new periods.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rate_code_i | input | 3 | New rate code, sampled when rate_wr_i is high |
| rate_wr_i | input | 1 | One-cycle write strobe for the rate code |
| cpu_en_o | output | 1 | CPU advance enable, one master cycle wide |

## Verification
Each of the eight codes is written in the middle of a counter period and then left to run for two full periods. This pins down both the divisor of each code and the rule that a written code waits for the rollover. Two writes inside one period show that the last one wins. A write timed to land on the rollover edge shows that a code arriving at the boundary is taken at once and not one period later. Moving between the slowest and fastest codes covers the corner where a /1 rate meets the pulse that is always present at rollover.

// File: rtl/cpu_rate_pkg.sv
package cpu_rate_pkg;

  localparam int unsigned CODE_W  = 3;
  localparam int unsigned SHIFT_W = 4;
  localparam logic [CODE_W-1:0] RESET_CODE = 3'b010;

  // Rate code to log2 of the divisor. The mapping is deliberately
  // non-monotonic: the low half covers /8../1, the high half /16../256.
  function automatic logic [SHIFT_W-1:0] code_to_shift(input logic [CODE_W-1:0] code);
    logic [SHIFT_W-1:0] s;
    case (code)
      3'b000:  s = 4'd3;
      3'b001:  s = 4'd2;
      3'b010:  s = 4'd1;
      3'b011:  s = 4'd0;
      3'b100:  s = 4'd4;
      3'b101:  s = 4'd5;
      3'b110:  s = 4'd7;
      default: s = 4'd8;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/rate_div_chain.sv
module rate_div_chain #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = &cnt_q;

endmodule

// File: rtl/rate_sel_hold.sv
module rate_sel_hold
  import cpu_rate_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] code_i,
  input  logic              wr_i,
  input  logic              wrap_i,
  output logic [CODE_W-1:0] act_code_o
);

  logic [CODE_W-1:0] pend_q;
  logic [CODE_W-1:0] act_q;
  logic [CODE_W-1:0] pend_next;

  // The strobe forwards straight to the pending value, so a write that
  // lands on the rollover edge is taken at that rollover.
  assign pend_next = wr_i ? code_i : pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= RESET_CODE;
      act_q  <= RESET_CODE;
    end else begin
      pend_q <= pend_next;
      if (wrap_i) act_q <= pend_next;
    end
  end

  assign act_code_o = act_q;

endmodule

// File: rtl/rate_tap_select.sv
module rate_tap_select
  import cpu_rate_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [CNT_W-1:0]   cnt_i,
  input  logic [SHIFT_W-1:0] shift_i,
  output logic               en_o
);

  logic [CNT_W-1:0] mask;
  logic             hit;
  logic             en_q;

  // Tap mask: ones on the bits below the selected shift.
  for (genvar i = 0; i < CNT_W; i++) begin : g_mask
    assign mask[i] = (i < int'(shift_i));
  end

  // Every masked bit at its terminal value means this tap is due.
  assign hit = &(cnt_i | ~mask);

  // Output register ties the pulse to the master clock.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else         en_q <= hit;
  end

  assign en_o = en_q;

endmodule

// File: rtl/cpu_rate_gen.sv
module cpu_rate_gen
  import cpu_rate_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] rate_code_i,
  input  logic              rate_wr_i,
  output logic              cpu_en_o
);

  logic [CNT_W-1:0]   cnt_w;
  logic               wrap_w;
  logic [CODE_W-1:0]  act_code_w;
  logic [SHIFT_W-1:0] act_shift_w;

  rate_div_chain #(.CNT_W(CNT_W)) u_chain (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cnt_o  (cnt_w),
    .wrap_o (wrap_w)
  );

  rate_sel_hold u_hold (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .code_i     (rate_code_i),
    .wr_i       (rate_wr_i),
    .wrap_i     (wrap_w),
    .act_code_o (act_code_w)
  );

  assign act_shift_w = code_to_shift(act_code_w);

  rate_tap_select #(.CNT_W(CNT_W)) u_tap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cnt_i   (cnt_w),
    .shift_i (act_shift_w),
    .en_o    (cpu_en_o)
  );

endmodule

// File: rtl/cpu_rate_gen_chk.sv
module cpu_rate_gen_chk
  import cpu_rate_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CODE_W-1:0]  code,
  input  logic               wr,
  input  logic               en,
  input  logic [CNT_W-1:0]   cnt,
  input  logic [CODE_W-1:0]  act_code,
  input  logic [SHIFT_W-1:0] act_shift
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> !en);

  // R4
  full_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_shift == '0 |=> en);

  // R5
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && act_shift != '0 && cnt != '0) |=> !en);

  // R6
  hold_until_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(&cnt) |=> $stable(act_code));

  // R8
  wrap_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((&cnt) && wr) |=> act_code == $past(code));

  // R9
  wrap_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&cnt) |=> en);

endmodule

bind cpu_rate_gen cpu_rate_gen_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk_i),
  .rst_n     (rst_ni),
  .code      (rate_code_i),
  .wr        (rate_wr_i),
  .en        (cpu_en_o),
  .cnt       (cnt_w),
  .act_code  (act_code_w),
  .act_shift (act_shift_w)
);

// File: tb/sim_cpu_rate_gen.sv
`timescale 1ns/1ps
module sim_cpu_rate_gen;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] code = 3'b000;
  logic       wr = 1'b0;
  logic       cpu_en;

  int n_chk = 0;
  int n_fail = 0;
  int k = 0;
  int cyc = 0;
  logic [2:0] m_act = 3'b010;
  logic [2:0] m_pend = 3'b010;

  always #2 clk = ~clk;

  cpu_rate_gen u0 (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .rate_code_i (code),
    .rate_wr_i   (wr),
    .cpu_en_o    (cpu_en)
  );

  // Divisor per code as given in R2 and R3.
  function automatic int divisor(input logic [2:0] c);
    case (c)
      3'b000: return 8;
      3'b001: return 4;
      3'b010: return 2;
      3'b011: return 1;
      3'b100: return 16;
      3'b101: return 32;
      3'b110: return 128;
      default: return 256;
    endcase
  endfunction

  task automatic check(input logic act, input logic exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s edge %0d code %b: cpu_en=%b expected %b", req, k, m_act, act, exp);
    end
  endtask

  // One master cycle: drive at negedge, update the model at the edge,
  // compare at the following negedge.
  task automatic step(input logic w, input logic [2:0] c);
    string tag;
    logic exp;
    wr = w;
    code = c;
    @(posedge clk);
    k++;
    if (k % 256 == 0) m_act = w ? c : m_pend;
    if (w) m_pend = c;
    exp = (k % divisor(m_act)) == 0;
    if (k % 256 == 0)          tag = w ? "R8" : "R9";
    else if (m_pend != m_act)  tag = "R6";
    else if (m_act == 3'b011)  tag = "R4";
    else if (!exp && k % divisor(m_act) == 1) tag = "R5";
    else if (m_act[2])         tag = "R3";
    else                       tag = "R2";
    @(negedge clk);
    check(cpu_en, exp, tag);
    wr = 1'b0;
  endtask

  task automatic run_to(input int phase);
    while ((k + 1) % 256 != phase) step(1'b0, 3'b000);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected end before 100000 cycles");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(cpu_en, 1'b0, "R1");
    @(negedge clk);
    rst_n = 1'b1;
    // R1: default divide by 2 after reset
    for (int i = 0; i < 300; i++) step(1'b0, 3'b000);

    // R2 / R3 / R6: each code written mid-period, run two full periods
    for (int c = 0; c < 8; c++) begin
      run_to(100);
      step(1'b1, 3'(c));
      for (int i = 0; i < 520; i++) step(1'b0, 3'b000);
    end

    // R7: two writes in one period, last one wins
    run_to(40);
    step(1'b1, 3'b110);
    for (int i = 0; i < 30; i++) step(1'b0, 3'b000);
    step(1'b1, 3'b011);
    for (int i = 0; i < 300; i++) step(1'b0, 3'b000);

    // R8: write lands on the rollover edge
    run_to(0);
    step(1'b1, 3'b101);
    for (int i = 0; i < 300; i++) step(1'b0, 3'b000);

    // R5 / R9: slowest to fastest and back across rollovers
    run_to(0);
    step(1'b1, 3'b111);
    for (int i = 0; i < 255; i++) step(1'b0, 3'b000);
    step(1'b1, 3'b011);
    for (int i = 0; i < 255; i++) step(1'b0, 3'b000);
    step(1'b1, 3'b000);
    for (int i = 0; i < 300; i++) step(1'b0, 3'b000);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule